// File: doc/BRIEF.md
# Reset Cause Recorder and Low-Power Entry Gate

This block is a small register-mapped control unit for system integration. It keeps a sticky record of which kinds of reset have happened since power-on. Software can read that record and clear it. The block also holds one 2-bit disable code for each of two low-power modes, STOP and WAIT. The code decides whether the core's request to enter that mode is passed on. One code value locks the field against further change until the next reset.

The register bus is simple and synchronous. A write is taken at the rising clock edge when the write enable is high. Read data is a combinational function of the address. The power-on reset is asynchronous and active low, and it initializes everything. The software, watchdog and external reset causes arrive as single-cycle pulses while the block stays clocked. Each pulse updates the cause record and releases the disable fields.

Register map:
- Offset 0 is the control register. Bits 1:0 hold the WAIT disable code and bits 3:2 hold the STOP disable code.
- Offset 1 is the status register. Bit 5 is software reset, bit 4 is watchdog reset, bit 3 is external reset and bit 2 is power-on reset.
- All other bits and all other offsets read 0.

Top module: `lpc_sysctl`

## Requirements
- R1: While por_n is low and after it is released, the status register reads 0x0004 and the control register reads 0x0000.
- R2: When a mode's disable code is 00, its enter output equals its request input in the same cycle. When the code is anything else, the enter output is 0.
- R3: Code 01 blocks entry and the field stays writable, so a later write of 00 takes effect.
- R4: Codes 10 and 11 block entry and lock the field. Writes to a locked field are ignored, and reads still return the held code. The STOP and WAIT fields lock independently.
- R5: A software, watchdog or external reset pulse returns both disable fields to 00, which releases any lock. The control register shows this from the next cycle.
- R6: A reset pulse sets its own status bit from the next cycle: bit 5 for software, bit 4 for watchdog, bit 3 for external. Bits set earlier are kept, except as R7 states.
- R7: A watchdog or external pulse clears status bit 5. If a software pulse arrives in the same cycle, bit 5 is set instead.
- R8: A status write sets each of bits 5, 4 and 3 where the written bit is 0, and clears it where the written bit is 1. Bit 2 is cleared by writing 1 and is unchanged by writing 0.
- R9: Status bits 15:6, control bits 15:4, and every offset other than 0 and 1 read 0. Writes to them have no effect.
- R10: A register write in the same cycle as a reset pulse is ignored. The register then shows only the effect of the pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| bus_addr | input | ADDR_W | Register offset |
| bus_wr | input | 1 | Write enable, taken at the clock edge |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr (combinational) |
| sw_rst_pulse | input | 1 | Software reset occurred (one cycle) |
| cop_rst_pulse | input | 1 | Watchdog reset occurred (one cycle) |
| ext_rst_pulse | input | 1 | External pin reset occurred (one cycle) |
| stop_req | input | 1 | Core requests STOP mode |
| wait_req | input | 1 | Core requests WAIT mode |
| stop_enter | output | 1 | STOP entry granted |
| wait_enter | output | 1 | WAIT entry granted |

## Verification
Some properties are checked on every cycle:
- an enter output is only raised while its request is high and its field is 00;
- a locked field does not change without a reset pulse;
- every reset pulse clears both fields and sets its own status bit;
- a watchdog or external pulse without a software pulse clears the software bit;
- reserved status bits always read 0.

Other behaviour can only be shown by the bench's scenarios:
- the inverted write polarity of the status bits;
- cause bits accumulating over a sequence of different resets;
- a lock surviving a long run of writes;
- writes dropped in a reset cycle.

Random traffic is compared against a reference model on every cycle.

// File: rtl/lpc_pkg.sv
package lpc_pkg;
    localparam int unsigned NUM_MODES  = 2;
    localparam int unsigned FIELD_W    = 2;
    localparam int unsigned MODE_WAIT  = 0;
    localparam int unsigned MODE_STOP  = 1;
    localparam int unsigned CTRL_OFS   = 0;
    localparam int unsigned STAT_OFS   = 1;
    localparam int unsigned STAT_LSB   = 2;
    localparam int unsigned STAT_W     = 4;
    localparam int unsigned STAT_TOP   = STAT_LSB + STAT_W;

    localparam logic [FIELD_W-1:0] DIS_ALLOW = 2'b00;
    localparam logic [FIELD_W-1:0] DIS_SOFT  = 2'b01;

    typedef struct packed {
        logic swr;
        logic copr;
        logic extr;
        logic porr;
    } rst_flags_t;

    typedef struct packed {
        logic [FIELD_W-1:0] code;
    } gate_state_t;
endpackage

// File: rtl/lpc_mode_gate.sv
module lpc_mode_gate
    import lpc_pkg::*;
(
    input  logic               clk,
    input  logic               por_n,
    input  logic               rst_any,
    input  logic               wr_sel,
    input  logic [FIELD_W-1:0] wr_code,
    input  logic               req,
    output logic [FIELD_W-1:0] code,
    output logic               enter
);
    gate_state_t st_d, st_q;
    logic        locked;

    assign locked = st_q.code[FIELD_W-1];

    always_comb begin
        st_d = st_q;
        if (rst_any) begin
            st_d.code = DIS_ALLOW;
        end else if (wr_sel && !locked) begin
            st_d.code = wr_code;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q <= '{code: DIS_ALLOW};
        end else begin
            st_q <= st_d;
        end
    end

    assign code  = st_q.code;
    assign enter = req && (st_q.code == DIS_ALLOW);
endmodule

// File: rtl/lpc_rst_flags.sv
module lpc_rst_flags
    import lpc_pkg::*;
(
    input  logic              clk,
    input  logic              por_n,
    input  logic              sw_pulse,
    input  logic              cop_pulse,
    input  logic              ext_pulse,
    input  logic              wr_sel,
    input  logic [STAT_W-1:0] wr_bits,
    output rst_flags_t        flags
);
    rst_flags_t fl_d, fl_q;
    rst_flags_t wr_view;
    logic       hw_pulse;

    assign wr_view  = rst_flags_t'(wr_bits);
    assign hw_pulse = cop_pulse || ext_pulse;

    always_comb begin
        fl_d = fl_q;
        if (sw_pulse || hw_pulse) begin
            if (cop_pulse) fl_d.copr = 1'b1;
            if (ext_pulse) fl_d.extr = 1'b1;
            if (sw_pulse) begin
                fl_d.swr = 1'b1;
            end else begin
                fl_d.swr = 1'b0;
            end
        end else if (wr_sel) begin
            fl_d.swr  = ~wr_view.swr;
            fl_d.copr = ~wr_view.copr;
            fl_d.extr = ~wr_view.extr;
            if (wr_view.porr) fl_d.porr = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            fl_q <= '{swr: 1'b0, copr: 1'b0, extr: 1'b0, porr: 1'b1};
        end else begin
            fl_q <= fl_d;
        end
    end

    assign flags = fl_q;
endmodule

// File: rtl/lpc_sysctl.sv
module lpc_sysctl
    import lpc_pkg::*;
#(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              sw_rst_pulse,
    input  logic              cop_rst_pulse,
    input  logic              ext_rst_pulse,
    input  logic              stop_req,
    input  logic              wait_req,
    output logic              stop_enter,
    output logic              wait_enter
);
    localparam int unsigned CTRL_W = NUM_MODES * FIELD_W;

    logic                  rst_any;
    logic                  sel_ctrl, sel_stat;
    logic                  wr_ctrl, wr_stat;
    logic [NUM_MODES-1:0]  req_vec, enter_vec;
    logic [CTRL_W-1:0]     ctrl_fields;
    rst_flags_t            flags;
    logic [STAT_W-1:0]     flag_vec;

    assign rst_any  = sw_rst_pulse || cop_rst_pulse || ext_rst_pulse;
    assign sel_ctrl = (bus_addr == ADDR_W'(CTRL_OFS));
    assign sel_stat = (bus_addr == ADDR_W'(STAT_OFS));
    assign wr_ctrl  = bus_wr && sel_ctrl && !rst_any;
    assign wr_stat  = bus_wr && sel_stat && !rst_any;

    assign req_vec[MODE_WAIT] = wait_req;
    assign req_vec[MODE_STOP] = stop_req;
    assign wait_enter = enter_vec[MODE_WAIT];
    assign stop_enter = enter_vec[MODE_STOP];

    for (genvar m = 0; m < NUM_MODES; m++) begin : g_mode
        lpc_mode_gate u_gate (
            .clk     (clk),
            .por_n   (por_n),
            .rst_any (rst_any),
            .wr_sel  (wr_ctrl),
            .wr_code (bus_wdata[m*FIELD_W +: FIELD_W]),
            .req     (req_vec[m]),
            .code    (ctrl_fields[m*FIELD_W +: FIELD_W]),
            .enter   (enter_vec[m])
        );
    end

    lpc_rst_flags u_flags (
        .clk       (clk),
        .por_n     (por_n),
        .sw_pulse  (sw_rst_pulse),
        .cop_pulse (cop_rst_pulse),
        .ext_pulse (ext_rst_pulse),
        .wr_sel    (wr_stat),
        .wr_bits   (bus_wdata[STAT_LSB +: STAT_W]),
        .flags     (flags)
    );

    assign flag_vec = flags;

    always_comb begin
        bus_rdata = '0;
        if (sel_ctrl) begin
            bus_rdata[CTRL_W-1:0] = ctrl_fields;
        end else if (sel_stat) begin
            bus_rdata[STAT_LSB +: STAT_W] = flag_vec;
        end
    end
endmodule

// File: rtl/lpc_sysctl_chk.sv
module lpc_sysctl_chk #(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 16
) (
    input logic              clk,
    input logic              por_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              sw_rst_pulse,
    input logic              cop_rst_pulse,
    input logic              ext_rst_pulse,
    input logic              stop_req,
    input logic              wait_req,
    input logic              stop_enter,
    input logic              wait_enter,
    input logic [3:0]        ctrl_fields,
    input logic [3:0]        flag_vec
);
    logic any_pulse;
    assign any_pulse = sw_rst_pulse || cop_rst_pulse || ext_rst_pulse;

    // R2
    stop_grant_chk: assert property (@(posedge clk) disable iff (!por_n)
        stop_enter |-> (stop_req && ctrl_fields[3:2] == 2'b00));
    // R2
    wait_grant_chk: assert property (@(posedge clk) disable iff (!por_n)
        wait_enter |-> (wait_req && ctrl_fields[1:0] == 2'b00));
    // R4
    stop_lock_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        (ctrl_fields[3] && !any_pulse) |=> $stable(ctrl_fields[3:2]));
    // R4
    wait_lock_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        (ctrl_fields[1] && !any_pulse) |=> $stable(ctrl_fields[1:0]));
    // R5
    lock_release_chk: assert property (@(posedge clk) disable iff (!por_n)
        any_pulse |=> (ctrl_fields == 4'b0000));
    // R6
    ext_flag_set_chk: assert property (@(posedge clk) disable iff (!por_n)
        ext_rst_pulse |=> flag_vec[1]);
    // R6
    cop_flag_set_chk: assert property (@(posedge clk) disable iff (!por_n)
        cop_rst_pulse |=> flag_vec[2]);
    // R6
    sw_flag_set_chk: assert property (@(posedge clk) disable iff (!por_n)
        sw_rst_pulse |=> flag_vec[3]);
    // R6
    por_flag_kept_chk: assert property (@(posedge clk) disable iff (!por_n)
        (any_pulse && flag_vec[0]) |=> flag_vec[0]);
    // R7
    swr_hw_clear_chk: assert property (@(posedge clk) disable iff (!por_n)
        ((cop_rst_pulse || ext_rst_pulse) && !sw_rst_pulse) |=> !flag_vec[3]);
    // R9
    stat_reserved_chk: assert property (@(posedge clk) disable iff (!por_n)
        (bus_addr == ADDR_W'(1)) |-> (bus_rdata[DATA_W-1:6] == '0));
endmodule

bind lpc_sysctl lpc_sysctl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk           (clk),
    .por_n         (por_n),
    .bus_addr      (bus_addr),
    .bus_rdata     (bus_rdata),
    .sw_rst_pulse  (sw_rst_pulse),
    .cop_rst_pulse (cop_rst_pulse),
    .ext_rst_pulse (ext_rst_pulse),
    .stop_req      (stop_req),
    .wait_req      (wait_req),
    .stop_enter    (stop_enter),
    .wait_enter    (wait_enter),
    .ctrl_fields   (ctrl_fields),
    .flag_vec      (flag_vec)
);

// File: tb/tb_lpc_sysctl.sv
module tb_lpc_sysctl;
    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        sw_rst_pulse = 1'b0, cop_rst_pulse = 1'b0, ext_rst_pulse = 1'b0;
    logic        stop_req = 1'b0, wait_req = 1'b0;
    logic        stop_enter, wait_enter;

    int unsigned n_chk = 0;
    int unsigned n_bad = 0;
    bit          done = 1'b0;

    // model: m_ctrl = {stop[1:0], wait[1:0]}, m_flags = {sw, cop, ext, por}
    logic [3:0] m_ctrl;
    logic [3:0] m_flags;

    always #5 clk = ~clk;

    lpc_sysctl dut (
        .clk(clk), .por_n(por_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sw_rst_pulse(sw_rst_pulse), .cop_rst_pulse(cop_rst_pulse),
        .ext_rst_pulse(ext_rst_pulse), .stop_req(stop_req), .wait_req(wait_req),
        .stop_enter(stop_enter), .wait_enter(wait_enter)
    );

    task automatic chk(input logic [15:0] got, input logic [15:0] exp, input string tag);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%04h expected 0x%04h", tag, got, exp);
        end
    endtask

    function automatic logic [15:0] exp_read(input logic [3:0] a);
        if (a == 4'd0) return {12'h000, m_ctrl};
        if (a == 4'd1) return {10'h000, m_flags, 2'b00};
        return 16'h0000;
    endfunction

    function automatic logic [3:0] nx_ctrl(input logic [3:0] a, input logic w,
                                           input logic [15:0] d, input logic rst);
        logic [3:0] n = m_ctrl;
        if (rst) return 4'b0000;
        if (w && a == 4'd0) begin
            if (!m_ctrl[1]) n[1:0] = d[1:0];
            if (!m_ctrl[3]) n[3:2] = d[3:2];
        end
        return n;
    endfunction

    function automatic logic [3:0] nx_flags(input logic [3:0] a, input logic w,
                                            input logic [15:0] d,
                                            input logic s, input logic c, input logic e);
        logic [3:0] n = m_flags;
        if (s || c || e) begin
            if (c) n[2] = 1'b1;
            if (e) n[1] = 1'b1;
            n[3] = s;
            return n;
        end
        if (w && a == 4'd1) begin
            n[3] = ~d[5];
            n[2] = ~d[4];
            n[1] = ~d[3];
            if (d[2]) n[0] = 1'b0;
        end
        return n;
    endfunction

    // one bus cycle, entered just after a falling edge
    task automatic cyc(input logic [3:0] a, input logic w, input logic [15:0] d,
                       input logic s, input logic c, input logic e,
                       input logic sr, input logic wq, input string tag);
        logic [3:0] nc, nf;
        bus_addr = a; bus_wr = w; bus_wdata = d;
        sw_rst_pulse = s; cop_rst_pulse = c; ext_rst_pulse = e;
        stop_req = sr; wait_req = wq;
        #1;
        chk({15'd0, stop_enter}, {15'd0, sr && m_ctrl[3:2] == 2'b00}, {tag, " R2 stop_enter"});
        chk({15'd0, wait_enter}, {15'd0, wq && m_ctrl[1:0] == 2'b00}, {tag, " R2 wait_enter"});
        chk(bus_rdata, exp_read(a), {tag, " R9 rdata"});
        nc = nx_ctrl(a, w, d, s || c || e);
        nf = nx_flags(a, w, d, s, c, e);
        @(posedge clk);
        m_ctrl = nc;
        m_flags = nf;
        @(negedge clk);
        bus_wr = 1'b0;
        sw_rst_pulse = 1'b0; cop_rst_pulse = 1'b0; ext_rst_pulse = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input string tag);
        cyc(a, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, tag);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
        end
    end

    initial begin
        int unsigned seed;
        seed = 32'd5150;
        void'($urandom(seed));
        m_ctrl = 4'b0000;
        m_flags = 4'b0001;
        repeat (3) @(negedge clk);
        // R1: values while held in reset
        bus_addr = 4'd1; #1;
        chk(bus_rdata, 16'h0004, "R1 status during por");
        bus_addr = 4'd0; #1;
        chk(bus_rdata, 16'h0000, "R1 control during por");
        por_n = 1'b1;
        @(negedge clk);
        rd(4'd1, "R1 status after por");
        rd(4'd0, "R1 control after por");

        // R3: soft block, still writable
        cyc(4'd0, 1'b1, 16'h0005, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R3 write 01");
        cyc(4'd0, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R3 blocked");
        cyc(4'd0, 1'b1, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R3 rewrite 00");
        cyc(4'd0, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R3 allowed again");

        // R4: lock stop with 10, wait with 11; many writes
        cyc(4'd0, 1'b1, 16'h0008, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R4 lock stop");
        cyc(4'd0, 1'b1, 16'h0003, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R4 lock wait");
        for (int i = 0; i < 24; i++)
            cyc(4'd0, 1'b1, 16'($urandom()), 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R4 persist");
        chk(exp_read(4'd0), 16'h000B, "R4 model held code");
        rd(4'd0, "R4 locked read");

        // R5 + R6: external reset releases locks and sets bit 3
        cyc(4'd0, 1'b0, 16'h0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, "R5 ext pulse");
        rd(4'd0, "R5 released");
        rd(4'd1, "R6 ext set");
        // R6: watchdog reset accumulates
        cyc(4'd1, 1'b0, 16'h0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R6 cop pulse");
        rd(4'd1, "R6 accumulated");
        chk(exp_read(4'd1), 16'h001C, "R6 model accumulate");

        // R7: software bit then hardware clears it
        cyc(4'd1, 1'b0, 16'h0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R7 sw pulse");
        rd(4'd1, "R7 sw set");
        cyc(4'd1, 1'b0, 16'h0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R7 ext pulse");
        rd(4'd1, "R7 sw cleared");
        cyc(4'd1, 1'b0, 16'h0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R7 sw+cop");
        rd(4'd1, "R7 sw wins");

        // R8: inverted polarity
        cyc(4'd1, 1'b1, 16'hFFFF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R8 write ones");
        rd(4'd1, "R8 all cleared");
        chk(exp_read(4'd1), 16'h0000, "R8 model cleared");
        cyc(4'd1, 1'b1, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R8 write zeros");
        rd(4'd1, "R8 zero sets");
        chk(exp_read(4'd1), 16'h0038, "R8 model set");

        // R9: reserved bits and unmapped offsets
        cyc(4'd0, 1'b1, 16'hFFF0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R9 ctrl reserved write");
        rd(4'd0, "R9 ctrl reserved read");
        cyc(4'd7, 1'b1, 16'hFFFF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R9 unmapped write");
        rd(4'd7, "R9 unmapped read");
        rd(4'd1, "R9 status untouched");

        // R10: write during reset pulse dropped
        cyc(4'd0, 1'b1, 16'h0009, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, "R10 ctrl write+pulse");
        rd(4'd0, "R10 ctrl unchanged");
        cyc(4'd1, 1'b1, 16'h003C, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R10 stat write+pulse");
        rd(4'd1, "R10 stat pulse only");

        // random traffic
        for (int i = 0; i < 3000; i++) begin
            logic [3:0] a;
            int unsigned r;
            r = $urandom_range(99);
            a = (r < 45) ? 4'd0 : (r < 90) ? 4'd1 : 4'($urandom_range(15));
            cyc(a, $urandom_range(1) == 1, 16'($urandom()),
                $urandom_range(60) == 0, $urandom_range(60) == 0, $urandom_range(60) == 0,
                $urandom_range(1) == 1, $urandom_range(1) == 1, "random R2 R4 R6 R8");
        end

        done = 1'b1;
        summary();
    end
endmodule